// File: doc/BRIEF.md
# Memory-Mapped Signed Division Unit

This block is a signed integer divider that sits on a simple peripheral register bus. Software first stores a divisor. It then starts one of two operations. A single-word division starts when the dividend is written to its launch register. A double-word division starts when the upper dividend half is stored in the high-word register and the lower half is then written to a second launch register. Every operand is a two's complement value.

The core works on magnitudes. It produces one quotient bit per clock with a restoring shift-and-subtract loop. A busy output is high while the loop runs. When the loop ends, the signed quotient and remainder are written into fixed result registers, and each result goes to more than one register. When the divisor is zero, a launch write behaves like an ordinary store and starts nothing.

Top module: `sdiv_unit`

Register offsets are byte addresses and must be word aligned: divisor 0x100, single-word launch 0x104, high word / remainder 0x110, double-word launch / quotient 0x114, remainder copy 0x118, quotient copy 0x11C.

## Requirements
- R1: After reset, all six registers read zero and busy is low.
- R2: A write while busy is low stores the data in the register at that exact word-aligned offset, where it can be read back. A read of any other offset, including a misaligned one, returns zero.
- R3: A write to 0x104 while the divisor is nonzero starts a single-word division of the written value by the divisor. Busy rises on the next cycle and stays high for exactly W+1 cycles.
- R4: A write to 0x114 while the divisor is nonzero starts a double-word division with dividend {0x110, written value}. Busy stays high for exactly 2W+1 cycles.
- R5: When a single-word division completes, the quotient is in 0x104, 0x114 and 0x11C, and the remainder is in 0x110 and 0x118.
- R6: When a double-word division completes, the quotient is in 0x114 and 0x11C and the remainder is in 0x110 and 0x118. Register 0x104 keeps its earlier contents.
- R7: The quotient is truncated toward zero. The remainder is zero or has the sign of the dividend, and its magnitude is smaller than the divisor's.
- R8: When the divisor is zero, a launch write only stores its data. Busy stays low and no other register changes.
- R9: While busy is high, every register reads its previous contents, including the operand just written, and all bus writes are ignored.
- R10: When a double-word quotient does not fit in W bits, the quotient registers receive the low W bits of the truncated quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | W | Write data |
| rdData | output | W | Read data for addr (combinational) |
| busy | output | 1 | High while a division runs |

## Verification
The bench builds the unit with W=16 and ADDR_W=9. With 16-bit words, random draws often hit the most negative value, minus one, zero and divisors larger than the dividend. Double-word dividends that overflow a 16-bit quotient also come up often. Each division takes at most 33 cycles, so many mixed single- and double-word operations fit in a short run, and every one is checked against a reference model of all six registers.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  localparam int unsigned NREG = 6;

  localparam int unsigned IDX_DIVISOR = 0;  // divisor
  localparam int unsigned IDX_DVD32   = 1;  // single-word launch / quotient
  localparam int unsigned IDX_REMHI   = 2;  // high dividend word / remainder
  localparam int unsigned IDX_QUOLO   = 3;  // double-word launch / quotient
  localparam int unsigned IDX_REMMIR  = 4;  // remainder copy
  localparam int unsigned IDX_QUOMIR  = 5;  // quotient copy

  function automatic int unsigned regOffset(input int unsigned idx);
    case (idx)
      IDX_DIVISOR: return 32'h100;
      IDX_DVD32:   return 32'h104;
      IDX_REMHI:   return 32'h110;
      IDX_QUOLO:   return 32'h114;
      IDX_REMMIR:  return 32'h118;
      default:     return 32'h11C;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_COMMIT = 2'd2
  } divState_e;

  typedef struct packed {
    logic load;    // capture operands, start iterating
    logic wide;    // double-word operation
    logic step;    // one restoring iteration
    logic commit;  // write signed results to registers
  } divStrobe_t;

endpackage

// File: rtl/sdiv_regfile.sv
module sdiv_regfile
  import sdiv_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [W-1:0]             wrData,
  input  logic                     busy,
  input  logic                     commit,
  input  logic                     wideMode,
  input  logic [W-1:0]             quotient,
  input  logic [W-1:0]             remainder,
  output logic [NREG-1:0]          hitVec,
  output logic [NREG-1:0][W-1:0]   regQ,
  output logic [W-1:0]             rdData,
  output logic                     divisorZero
);

  logic [W-1:0]    regBank [NREG];
  logic [NREG-1:0] takeQuo;
  logic [NREG-1:0] takeRem;
  logic            wrAccept;

  assign wrAccept = wrEn && !busy;

  always_comb begin
    takeQuo = '0;
    takeRem = '0;
    takeQuo[IDX_QUOLO]  = 1'b1;
    takeQuo[IDX_QUOMIR] = 1'b1;
    takeQuo[IDX_DVD32]  = !wideMode;
    takeRem[IDX_REMHI]  = 1'b1;
    takeRem[IDX_REMMIR] = 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(regOffset(i));

    assign hitVec[i] = (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regBank[i] <= '0;
      else if (commit && takeQuo[i])
        regBank[i] <= quotient;
      else if (commit && takeRem[i])
        regBank[i] <= remainder;
      else if (wrAccept && hitVec[i])
        regBank[i] <= wrData;
    end

    assign regQ[i] = regBank[i];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hitVec[i]) rdData = regBank[i];
    end
  end

  assign divisorZero = (regBank[IDX_DIVISOR] == '0);

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       hitNarrow,
  input  logic       hitWide,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       busy
);

  localparam int CNT_W = $clog2(2 * W + 1);
  localparam logic [CNT_W-1:0] STEPS_NARROW = CNT_W'(W);
  localparam logic [CNT_W-1:0] STEPS_WIDE   = CNT_W'(2 * W);

  divState_e        stateQ;
  logic [CNT_W-1:0] stepCnt;
  logic             wideQ;
  logic             launch;

  assign busy   = (stateQ != ST_IDLE);
  assign launch = wrEn && !busy && (hitNarrow || hitWide) && !divisorZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      wideQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (launch) begin
            stateQ  <= ST_RUN;
            wideQ   <= hitWide;
            stepCnt <= hitWide ? STEPS_WIDE : STEPS_NARROW;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt - 1'b1;
          if (stepCnt == CNT_W'(1)) stateQ <= ST_COMMIT;
        end
        ST_COMMIT: stateQ <= ST_IDLE;
        default:   stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = launch;
    strobe.wide   = (stateQ == ST_IDLE) ? hitWide : wideQ;
    strobe.step   = (stateQ == ST_RUN);
    strobe.commit = (stateQ == ST_COMMIT);
  end

endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] hiWord,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int DW = 2 * W;

  logic [DW-1:0] dvdFull;
  logic [DW-1:0] dvdMag;
  logic [W-1:0]  divMagIn;

  logic [DW-1:0] dqQ;        // dividend bits shifted out, quotient bits shifted in
  logic [W-1:0]  partialQ;   // running partial remainder magnitude
  logic [W-1:0]  divMagQ;
  logic          qNegQ;
  logic          rNegQ;

  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  assign dvdFull  = strobe.wide ? {hiWord, wrData} : {{W{wrData[W-1]}}, wrData};
  assign dvdMag   = dvdFull[DW-1] ? (~dvdFull + 1'b1) : dvdFull;
  assign divMagIn = divisor[W-1] ? (~divisor + 1'b1) : divisor;

  assign trial = {partialQ, dqQ[DW-1]};
  assign diff  = trial - {1'b0, divMagQ};
  assign fits  = (trial >= {1'b0, divMagQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqQ      <= '0;
      partialQ <= '0;
      divMagQ  <= '0;
      qNegQ    <= 1'b0;
      rNegQ    <= 1'b0;
    end else if (strobe.load) begin
      // a single-word magnitude sits in the upper half so only W steps are needed
      dqQ      <= strobe.wide ? dvdMag : {dvdMag[W-1:0], {W{1'b0}}};
      partialQ <= '0;
      divMagQ  <= divMagIn;
      qNegQ    <= dvdFull[DW-1] ^ divisor[W-1];
      rNegQ    <= dvdFull[DW-1];
    end else if (strobe.step) begin
      dqQ      <= {dqQ[DW-2:0], fits};
      partialQ <= fits ? diff[W-1:0] : trial[W-1:0];
    end else if (strobe.commit) begin
      dqQ      <= '0;
      partialQ <= '0;
    end
  end

  assign quotient  = qNegQ ? (~dqQ[W-1:0] + 1'b1) : dqQ[W-1:0];
  assign remainder = rNegQ ? (~partialQ + 1'b1) : partialQ;

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData,
  output logic              busy
);

  divStrobe_t             strobe;
  logic [NREG-1:0]        hitVec;
  logic [NREG-1:0][W-1:0] regQ;
  logic                   divisorZero;
  logic [W-1:0]           quotient;
  logic [W-1:0]           remainder;

  sdiv_regfile #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .addr        (addr),
    .wrData      (wrData),
    .busy        (busy),
    .commit      (strobe.commit),
    .wideMode    (strobe.wide),
    .quotient    (quotient),
    .remainder   (remainder),
    .hitVec      (hitVec),
    .regQ        (regQ),
    .rdData      (rdData),
    .divisorZero (divisorZero)
  );

  sdiv_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .hitNarrow   (hitVec[IDX_DVD32]),
    .hitWide     (hitVec[IDX_QUOLO]),
    .divisorZero (divisorZero),
    .strobe      (strobe),
    .busy        (busy)
  );

  sdiv_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .hiWord    (regQ[IDX_REMHI]),
    .divisor   (regQ[IDX_DIVISOR]),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker
  import sdiv_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 9
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [W-1:0]           wrData,
  input logic                   busy,
  input logic [NREG-1:0][W-1:0] regQ
);

  localparam logic [ADDR_W-1:0] A_NARROW = ADDR_W'(regOffset(IDX_DVD32));
  localparam logic [ADDR_W-1:0] A_WIDE   = ADDR_W'(regOffset(IDX_QUOLO));
  localparam int CW = $clog2(2 * W + 2) + 1;

  logic          launchHit;
  logic          wideSeen;
  logic          dvdSignSeen;
  logic [CW-1:0] busyLen;

  assign launchHit = wrEn && !busy && (addr == A_NARROW || addr == A_WIDE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideSeen    <= 1'b0;
      dvdSignSeen <= 1'b0;
      busyLen     <= '0;
    end else begin
      if (launchHit) begin
        wideSeen    <= (addr == A_WIDE);
        dvdSignSeen <= (addr == A_WIDE) ? regQ[IDX_REMHI][W-1] : wrData[W-1];
      end
      busyLen <= busy ? busyLen + 1'b1 : '0;
    end
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launchHit && (regQ[IDX_DIVISOR] != '0) |=> busy);  // R3

  AST_ZERO_DIVISOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    launchHit && (regQ[IDX_DIVISOR] == '0) |=> !busy);  // R8

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(regQ));  // R9

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == (wideSeen ? CW'(2 * W + 1) : CW'(W + 1))));  // R4

  AST_RESULT_MIRRORS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (regQ[IDX_QUOLO] == regQ[IDX_QUOMIR]) &&
                    (regQ[IDX_REMHI] == regQ[IDX_REMMIR]));  // R5

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && (regQ[IDX_REMHI] != '0) |-> (regQ[IDX_REMHI][W-1] == dvdSignSeen));  // R7

endmodule

bind sdiv_unit sdiv_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .busy   (busy),
  .regQ   (regQ)
);

// File: tb/sdiv_unit_tb.sv
`timescale 1ns/1ps
module sdiv_unit_tb;

  localparam int W  = 16;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wrData = '0;
  logic [W-1:0]  rdData;
  logic          busy;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0]  model [6];
  logic [AW-1:0] offs  [6] = '{9'h100, 9'h104, 9'h110, 9'h114, 9'h118, 9'h11C};

  always #10 clk = ~clk;

  sdiv_unit #(.W(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdData;
  endtask

  // returns {remainder, quotient}, both W bits
  function automatic logic [2*W-1:0] refDiv(input logic [2*W-1:0] dvd, input logic [W-1:0] dv);
    logic [2*W-1:0] dm, vm, q, r;
    dm = dvd[2*W-1] ? -dvd : dvd;
    vm = {{W{1'b0}}, (dv[W-1] ? -dv : dv)};
    q = dm / vm;
    r = dm % vm;
    if (dvd[2*W-1] ^ dv[W-1]) q = -q;
    if (dvd[2*W-1]) r = -r;
    return {r[W-1:0], q[W-1:0]};
  endfunction

  function automatic logic [W-1:0] pick();
    case ($urandom % 8)
      0: return '0;
      1: return '1;
      2: return {1'b1, {(W-1){1'b0}}};
      3: return W'(1);
      4: return W'($urandom % 8);
      default: return W'($urandom);
    endcase
  endfunction

  task automatic compareAll(input string req);
    logic [W-1:0] v;
    for (int i = 0; i < 6; i++) begin
      rd(offs[i], v);
      check(req, $sformatf("reg %h", offs[i]), v, model[i]);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic doOp(input bit wide, input logic [W-1:0] dv,
                      input logic [W-1:0] hi, input logic [W-1:0] lo);
    logic [2*W-1:0] res;
    int len;
    wr(9'h100, dv); model[0] = dv;
    if (wide) begin wr(9'h110, hi); model[2] = hi; end
    wr(wide ? 9'h114 : 9'h104, lo);
    model[wide ? 3 : 1] = lo;
    if (dv != '0) begin
      len = 0;
      while (busy && len < 1000) begin
        len++;
        @(negedge clk);
      end
      if (wide)
        check("R4", "busy length", W'(len), W'(2*W+1));
      else
        check("R3", "busy length", W'(len), W'(W+1));
      res = wide ? refDiv({hi, lo}, dv) : refDiv({{W{lo[W-1]}}, lo}, dv);
      if (!wide) model[1] = res[W-1:0];
      model[3] = res[W-1:0];
      model[5] = res[W-1:0];
      model[2] = res[2*W-1:W];
      model[4] = res[2*W-1:W];
      compareAll(wide ? "R6" : "R5");
    end else begin
      check("R8", "busy with zero divisor", W'(busy), '0);
      compareAll("R8");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [2*W-1:0] res;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1", "busy after reset", W'(busy), '0);
    compareAll("R1");

    // R2: plain stores, unmapped and misaligned reads
    wr(9'h118, 16'h5A5A); model[4] = 16'h5A5A;
    wr(9'h11C, 16'hC3C3); model[5] = 16'hC3C3;
    wr(9'h108, 16'h1111);
    rd(9'h108, v); check("R2", "unmapped read", v, '0);
    rd(9'h119, v); check("R2", "misaligned read", v, '0);
    compareAll("R2");

    // R8: zero divisor launch only stores
    doOp(1'b0, '0, '0, 16'h7777);
    doOp(1'b1, '0, 16'h0102, 16'h0304);

    // R7: truncation toward zero, remainder sign follows dividend
    doOp(1'b0, 16'd2, '0, -16'sd7);
    check("R7", "q -7/2", model[1], 16'hFFFD);
    rd(9'h110, v); check("R7", "r -7/2", v, 16'hFFFF);
    doOp(1'b0, -16'sd2, '0, 16'd7);
    rd(9'h104, v); check("R7", "q 7/-2", v, 16'hFFFD);
    rd(9'h118, v); check("R7", "r 7/-2", v, 16'h0001);

    // R9: frozen contents and ignored writes while busy
    wr(9'h100, 16'd7); model[0] = 16'd7;
    wr(9'h110, 16'd5); model[2] = 16'd5;
    wr(9'h114, 16'h1234); model[3] = 16'h1234;
    rd(9'h110, v); check("R9", "hi word during busy", v, 16'd5);
    rd(9'h114, v); check("R9", "launch operand during busy", v, 16'h1234);
    wr(9'h100, 16'd3);
    wr(9'h104, 16'h0F0F);
    check("R9", "still busy", W'(busy), W'(1));
    waitIdle();
    res = refDiv({16'd5, 16'h1234}, 16'd7);
    model[3] = res[W-1:0]; model[5] = res[W-1:0];
    model[2] = res[2*W-1:W]; model[4] = res[2*W-1:W];
    compareAll("R9");

    // R10: double-word quotients that overflow W bits
    doOp(1'b1, 16'hFFFF, 16'h8000, 16'h0000);
    check("R10", "q min/-1", model[3], 16'h0000);
    doOp(1'b1, 16'd1, 16'h0003, 16'h0000);
    rd(9'h11C, v); check("R10", "q 0x30000/1", v, 16'h0000);
    doOp(1'b1, 16'd3, 16'h7FFF, 16'hFFFF);

    // random mix
    for (int n = 0; n < 200; n++) begin
      bit wide = bit'($urandom % 2);
      doOp(wide, pick(), pick(), pick());
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule